// File: doc/BRIEF.md
# Inter-Core Interrupt Unit

This block lets any of N processor cores (N up to 4) raise an interrupt toward any other core and keeps a record of who raised it. Cores drive one shared command port: a valid strobe, a two-bit operation code, a core-number argument and the identity of the core issuing the command. Only one command is presented per cycle; choosing between cores that want to issue at the same time is done outside the block.

For every receiving core the unit holds one pending bit per possible sender. A receiver's interrupt line is high while any of its sender bits is set. Several raises toward the same receiver therefore merge into a single asserted line, and the receiver can read back the full set of senders. It then acknowledges each sender on its own. A status query lets a sender first check whether a target already has something pending. Query results land in a registered readback value that holds until the next query. A core interrupting itself is not supported here; that case belongs to a core-local soft interrupt.

Top module: `ipi_hub`

## Requirements
- R1: A valid raise command (op code 2'b00) from core C with argument T, where T differs from C, sets the pending bit for sender C at receiver T, so `irq[T]` is high in the cycle after the command.
- R2: A raise command whose argument equals the issuing core changes no pending bit and no `irq` output.
- R3: A valid status query (op code 2'b10) with argument T loads the readback with 1 in bit 0 and zeros above it if receiver T has any sender bit set, or with all zeros otherwise. The value is visible the cycle after the command.
- R4: A valid source query (op code 2'b11) from core C loads the readback with C's sender vector, where bit S is set if core S has a pending raise toward C. A single sender S reads as 1, 2, 4 or 8. The value is visible the cycle after the command.
- R5: Raises from several senders toward the same receiver merge into one asserted `irq` line, and a source query then shows all of those sender bits at once.
- R6: A valid acknowledge command (op code 2'b01) from core C with argument S clears only sender S's bit at receiver C. Every other pending bit is left untouched.
- R7: `irq[R]` stays high while any sender bit of receiver R remains set, and it falls only on the acknowledge that clears the last one.
- R8: A raise from a sender whose bit is already set leaves the bit set, and a single acknowledge then clears it.
- R9: Reset (synchronous, active low) clears every pending bit, every `irq` output and the readback.
- R10: The readback changes only on a query command. Raise and acknowledge commands, and idle cycles, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Operation: 00 raise, 01 acknowledge, 10 status query, 11 source query |
| cmd_arg | input | IDW | Core-number argument (target or sender) |
| cmd_core | input | IDW | Number of the core issuing the command |
| readback | output | N | Result of the most recent query |
| irq | output | N | Interrupt line toward each core |

## Verification
On every cycle the assertions check the following:
- A raise between distinct cores brings up the target's line, and a self-raise leaves all lines unchanged.
- Queries never disturb the lines, and no line falls except on an acknowledge.
- The readback follows the queried state and stays fixed between queries.

Only the bench's scenarios can show that an acknowledge removes exactly one sender out of several, that a line survives until its last sender is cleared, that duplicate raises collapse into one bit, and that reset clears everything. The bench checks these with a reference model of the full sender matrix, swept over every sender and receiver pair.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the inter-core interrupt unit.
package ipi_pkg;
    // Command operation codes; the encoding is visible at the port.
    typedef enum logic [1:0] {
        OP_RAISE = 2'b00,
        OP_ACK   = 2'b01,
        OP_PEEK  = 2'b10,
        OP_WHO   = 2'b11
    } ipi_op_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
`timescale 1ns/1ps
// Command decoder: turns one command into per-receiver set/clear strobes
// and one-hot forms of the argument and issuing core.
// Assumes at most one command per cycle and arg/core below N.
module ipi_cmd_decode #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [IDW-1:0] cmd_arg,
    input  logic [IDW-1:0] cmd_core,
    output logic [N-1:0]   set_rcv,
    output logic [N-1:0]   clr_rcv,
    output logic [N-1:0]   arg_hot,
    output logic [N-1:0]   core_hot,
    output logic           peek,
    output logic           who
);
    import ipi_pkg::*;

    ipi_op_e op;
    assign op = ipi_op_e'(cmd_op);

    // Query strobes for the readback stage.
    assign peek = cmd_valid && (op == OP_PEEK);
    assign who  = cmd_valid && (op == OP_WHO);

    // Per-core strobes; a raise toward the issuing core is dropped here.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            arg_hot[i]  = (cmd_arg == IDW'(i));
            core_hot[i] = (cmd_core == IDW'(i));
            set_rcv[i]  = cmd_valid && (op == OP_RAISE) && arg_hot[i] && !core_hot[i];
            clr_rcv[i]  = cmd_valid && (op == OP_ACK) && core_hot[i];
        end
    end
endmodule

// File: rtl/ipi_pend_row.sv
`timescale 1ns/1ps
// Pending-sender register for one receiving core. Holds one bit per sender
// and drives the receiver's interrupt line as the OR of those bits.
// Assumes set and clear are never requested in the same cycle.
module ipi_pend_row #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic [N-1:0] set_mask,
    input  logic         clr_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] pend,
    output logic         irq
);
    // Record new senders, drop acknowledged ones, clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else if (set_en)
            pend <= pend | set_mask;
        else if (clr_en)
            pend <= pend & ~clr_mask;
    end

    // Line is high while any sender remains recorded.
    assign irq = |pend;
endmodule

// File: rtl/ipi_readback.sv
`timescale 1ns/1ps
// Readback register: captures the result of a status or source query
// and holds it until the next query.
module ipi_readback #(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                peek,
    input  logic                who,
    input  logic [N-1:0]        arg_hot,
    input  logic [N-1:0]        core_hot,
    input  logic [N-1:0][N-1:0] pend_all,
    output logic [N-1:0]        readback
);
    logic         busy_bit;
    logic [N-1:0] src_vec;

    // Select the queried rows using the one-hot argument and core.
    always_comb begin
        busy_bit = 1'b0;
        src_vec  = '0;
        for (int i = 0; i < N; i++) begin
            busy_bit = busy_bit | (arg_hot[i] & (|pend_all[i]));
            src_vec  = src_vec | (core_hot[i] ? pend_all[i] : '0);
        end
    end

    // Load on a query, otherwise keep the previous result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            readback <= '0;
        else if (peek)
            readback <= {{(N-1){1'b0}}, busy_bit};
        else if (who)
            readback <= src_vec;
    end
endmodule

// File: rtl/ipi_hub.sv
`timescale 1ns/1ps
// Inter-core interrupt unit top. One command per cycle raises, acknowledges
// or queries per-receiver sender vectors; each receiver gets an irq line.
// Assumes external arbitration between issuing cores.
module ipi_hub #(
    parameter int N   = 4,
    parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [IDW-1:0] cmd_arg,
    input  logic [IDW-1:0] cmd_core,
    output logic [N-1:0]   readback,
    output logic [N-1:0]   irq
);
    logic [N-1:0]        set_rcv;
    logic [N-1:0]        clr_rcv;
    logic [N-1:0]        arg_hot;
    logic [N-1:0]        core_hot;
    logic                peek;
    logic                who;
    logic [N-1:0][N-1:0] pend_all;

    ipi_cmd_decode #(.N(N), .IDW(IDW)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg),
        .cmd_core  (cmd_core),
        .set_rcv   (set_rcv),
        .clr_rcv   (clr_rcv),
        .arg_hot   (arg_hot),
        .core_hot  (core_hot),
        .peek      (peek),
        .who       (who)
    );

    // One pending row per receiving core.
    for (genvar r = 0; r < N; r++) begin : g_row
        ipi_pend_row #(.N(N)) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (set_rcv[r]),
            .set_mask (core_hot),
            .clr_en   (clr_rcv[r]),
            .clr_mask (arg_hot),
            .pend     (pend_all[r]),
            .irq      (irq[r])
        );
    end

    ipi_readback #(.N(N)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .peek     (peek),
        .who      (who),
        .arg_hot  (arg_hot),
        .core_hot (core_hot),
        .pend_all (pend_all),
        .readback (readback)
    );
endmodule

// File: rtl/ipi_hub_chk.sv
`timescale 1ns/1ps
// Port-level checker for ipi_hub, attached by bind.
module ipi_hub_chk #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_valid,
    input logic [1:0]     cmd_op,
    input logic [IDW-1:0] cmd_arg,
    input logic [IDW-1:0] cmd_core,
    input logic [N-1:0]   readback,
    input logic [N-1:0]   irq
);
    // R1: a raise between distinct cores brings up the target line.
    p_raise_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b00 && cmd_arg != cmd_core) |=> irq[$past(cmd_arg)]);

    // R2: a self-raise leaves every line unchanged.
    p_self_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b00 && cmd_arg == cmd_core) |=> $stable(irq));

    // R3: a status query reports the target's line in bit 0.
    p_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b10) |=> (readback == N'($past(irq[cmd_arg]))));

    // R4: a source query is non-zero exactly when the issuer has a pending line.
    p_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b11) |=> ((readback != '0) == $past(irq[cmd_core])));

    // R7: no line falls except on an acknowledge.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == 2'b01) |=> (($past(irq) & ~irq) == '0));

    // R10: readback stays fixed unless a query is issued.
    p_rb_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op[1]) |=> $stable(readback));
endmodule

bind ipi_hub ipi_hub_chk #(.N(N), .IDW(IDW)) u_chk (.*);

// File: tb/sim_ipi_hub.sv
`timescale 1ns/1ps
module sim_ipi_hub;
    localparam int N   = 4;
    localparam int IDW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [1:0]     cmd_op = 2'b00;
    logic [IDW-1:0] cmd_arg = '0;
    logic [IDW-1:0] cmd_core = '0;
    logic [N-1:0]   readback;
    logic [N-1:0]   irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Reference state: mp[r][s] = sender s pending at receiver r.
    logic [N-1:0] mp [N];
    logic [N-1:0] exp_rb;

    always #5 clk = ~clk;

    ipi_hub #(.N(N), .IDW(IDW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_core(cmd_core), .readback(readback), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_irq();
        logic [N-1:0] v;
        for (int r = 0; r < N; r++) v[r] = |mp[r];
        return v;
    endfunction

    task automatic model_reset();
        for (int r = 0; r < N; r++) mp[r] = '0;
        exp_rb = '0;
    endtask

    // Issue one command, update the model, then check outputs a cycle later.
    task automatic cmd(input logic [1:0] op, input int arg, input int core, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = IDW'(arg); cmd_core = IDW'(core);
        case (op)
            2'b00: if (arg != core) mp[arg][core] = 1'b1;
            2'b01: mp[core][arg] = 1'b0;
            2'b10: exp_rb = N'(|mp[arg]);
            default: exp_rb = mp[core];
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({tag, " irq"}, 32'(irq), 32'(model_irq()));
        chk(op[1] ? {tag, " readback"} : "R10 readback", 32'(readback), 32'(exp_rb));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk("R9 irq after reset", 32'(irq), 0);
        chk("R9 readback after reset", 32'(readback), 0);
    endtask

    initial begin
        model_reset();
        do_reset();

        // Exhaustive raise sweep over all sender/receiver pairs (R1, R2).
        for (int s = 0; s < N; s++)
            for (int r = 0; r < N; r++)
                cmd(2'b00, r, s, (r == s) ? "R2 self raise" : "R1 raise");

        // Merged senders visible per receiver (R4, R5) and status per target (R3).
        for (int c = 0; c < N; c++) cmd(2'b11, 0, c, "R5 merged source");
        for (int t = 0; t < N; t++) cmd(2'b10, t, (t + 1) % N, "R3 status busy");

        // Acknowledge one sender at a time; line holds until the last (R6, R7).
        for (int r = 0; r < N; r++) begin
            for (int s = 0; s < N; s++) begin
                cmd(2'b01, s, r, "R7 ack partial");
                cmd(2'b11, 0, r, "R6 source after ack");
            end
        end
        for (int t = 0; t < N; t++) cmd(2'b10, t, 0, "R3 status idle");

        // Fresh single pairs: source value is one-hot of sender (R4).
        for (int s = 0; s < N; s++)
            for (int r = 0; r < N; r++) begin
                if (r == s) continue;
                cmd(2'b00, r, s, "R1 raise pair");
                cmd(2'b11, 0, r, "R4 single source");
                chk("R4 one-hot value", 32'(readback), 32'(1 << s));
                cmd(2'b01, s, r, "R6 ack pair");
            end

        // Duplicate raise collapses into one bit (R8).
        cmd(2'b00, 2, 1, "R8 first raise");
        cmd(2'b00, 2, 1, "R8 repeat raise");
        cmd(2'b11, 0, 2, "R8 source");
        cmd(2'b01, 1, 2, "R8 single ack");
        chk("R8 line low", 32'(irq[2]), 0);

        // Ack of one of two senders leaves the other (R6, R7).
        cmd(2'b00, 2, 1, "R1 raise");
        cmd(2'b00, 2, 3, "R5 second raise");
        cmd(2'b01, 3, 2, "R6 ack one of two");
        chk("R7 line still high", 32'(irq[2]), 1);
        cmd(2'b11, 0, 2, "R6 remaining source");
        cmd(2'b01, 0, 2, "R6 ack non-pending");

        // Reset in the middle clears everything (R9).
        cmd(2'b00, 1, 0, "R1 raise");
        cmd(2'b11, 0, 1, "R4 source");
        do_reset();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            errors++; checks++;
            $display("FAIL all watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule